// File: doc/BRIEF.md
# JTAG-Driven Burst Memory Access Engine

This block sits behind a debug scan selector and turns serial bit streams into bursts of single-beat accesses on a system bus. The host first scans in a command header that names an operation, a start address and a word count. For a write burst it then streams a start marker, the payload and a check code, and reads back one bit that reports whether the check code matched. For a read burst it sees zeros until the first word has been fetched, then a single ready marker, then the payload and a check code computed by the block.

The check code is a reflected CRC-32 built one bit at a time inside the block. The block also keeps a small error register. It records whether a bus beat failed and the byte address of the first beat that failed. The host reads this register with a no-op command scan and clears it with a one-bit register write. All scan traffic is qualified by capture, shift and update strobes in the same clock domain as the bus port. The bus port uses a request held until acknowledge or error.

Top module: `jtag_burst_engine`

## Requirements
- R1: After reset `dbg_tdo` is 0, `bus_stb` is 0, and the error register reads as all zeros.
- R2: A command scan is shifted least significant bit first and is acted on at `dbg_update`. The last bit shifted is a module flag and must be 0. The four bits before it are the opcode, then a 32-bit start address, then a 16-bit word count in the lowest bits. A header whose flag is 1 is ignored.
- R3: After a write header, shifted 0s are ignored until a 1 start marker. The payload follows, least significant bit first per word, then 32 CRC bits. The next shifted bit position shows 1 on `dbg_tdo` if the received CRC equals the computed one, and 0 otherwise.
- R4: After a read header, `dbg_tdo` is 0 until the first word has been fetched. It then shows a single 1, followed by the payload least significant bit first per word, then 32 CRC bits least significant bit first.
- R5: Opcodes 1/2/3 write and 5/6/7 read 8/16/32-bit words. `bus_size` is 0/1/2 and the byte address advances by 1/2/4 per beat. Bus data is right-justified with bytes in little-endian order.
- R6: The CRC is preset to all ones and covers exactly the payload bits in wire order. Each bit shifts the CRC right and XORs in 0xEDB88320 when the incoming bit differs from the CRC's low bit.
- R7: A burst performs exactly as many bus beats as the word count. A count of zero performs none and leaves the block idle.
- R8: A failed bus beat sets the error flag and stores its byte address, unless the flag is already set. Capture with index 0 selected loads 33 bits: bit 0 is the flag and bits 32..1 are the address. They are shifted out least significant bit first during a no-op (opcode 0) scan. Opcode 9 with index 0 and a data bit of 1 just before the index clears the register.
- R9: A bus error does not abort a burst. All remaining beats and the serial framing, including the match bit, continue unchanged.
- R10: Opcode 13 stores the index bit (the first bit of a 6-bit register command). Index 1 captures zeros. Opcodes 0, 4 and 13 start no bus beat and leave the error register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for scan strobes and bus port |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_capture | input | 1 | Capture strobe at the start of a scan |
| dbg_shift | input | 1 | One scan bit per cycle while high |
| dbg_update | input | 1 | End-of-scan strobe |
| dbg_tdi | input | 1 | Serial data from host |
| dbg_tdo | output | 1 | Serial data to host |
| bus_addr | output | 32 | Byte address of the current beat |
| bus_wdata | output | 32 | Right-justified write data |
| bus_rdata | input | 32 | Right-justified read data |
| bus_we | output | 1 | 1 for a write beat |
| bus_size | output | 2 | 0 byte, 1 half-word, 2 word |
| bus_stb | output | 1 | Beat request, held until ack or err |
| bus_ack | input | 1 | Beat completed |
| bus_err | input | 1 | Beat failed |

## Verification
The hardest situation to reach is a bus error in the middle of a multi-word write, followed by a check that the match bit, the beat count and the captured failing address all come out right. The bench's bus model answers with an error at one chosen address inside the burst. It then reads the error register through a no-op scan, switches the index to 1 and back to confirm the selection does not disturb the register, and clears it. The read tests depend on the real fetch latency, so the bench searches for the ready marker instead of assuming its position. The expected CRC is computed from the memory contents.

// File: rtl/jbe_pkg.sv
package jbe_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_NOP     = 4'd0;
    localparam logic [OPC_W-1:0] OPC_WR8     = 4'd1;
    localparam logic [OPC_W-1:0] OPC_WR16    = 4'd2;
    localparam logic [OPC_W-1:0] OPC_WR32    = 4'd3;
    localparam logic [OPC_W-1:0] OPC_RD8     = 4'd5;
    localparam logic [OPC_W-1:0] OPC_RD16    = 4'd6;
    localparam logic [OPC_W-1:0] OPC_RD32    = 4'd7;
    localparam logic [OPC_W-1:0] OPC_REG_WR  = 4'd9;
    localparam logic [OPC_W-1:0] OPC_REG_SEL = 4'd13;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_START,
        ST_WR_DATA,
        ST_WR_CRC,
        ST_WR_MATCH,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_RD_CRC,
        ST_DONE
    } eng_state_e;
endpackage

// File: rtl/jbe_crc32.sv
module jbe_crc32 #(
    parameter int               CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_s;

    crc_s crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d.crc = '1;
        end else if (en) begin
            crc_d.crc = (crc_q.crc >> 1) ^ ({CRC_W{crc_q.crc[0] ^ bit_in}} & POLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '{crc: '1};
        else        crc_q <= crc_d;
    end

    assign crc = crc_q.crc;

    // R6: the code never moves without a clear or an enabled bit
    assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/jbe_bus_port.sv
module jbe_bus_port #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        size,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic              bus_stb,
    input  logic              bus_ack,
    input  logic              bus_err
);
    typedef struct packed {
        logic              busy;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        size;
    } port_s;

    port_s port_d, port_q;
    logic  finish;

    always_comb begin
        port_d = port_q;
        finish = port_q.busy && (bus_ack || bus_err);
        if (finish) port_d.busy = 1'b0;
        if (start && !port_q.busy) begin
            port_d.busy  = 1'b1;
            port_d.we    = we;
            port_d.addr  = addr;
            port_d.wdata = wdata;
            port_d.size  = size;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign busy      = port_q.busy;
    assign done      = finish;
    assign fail      = port_q.busy && bus_err;
    assign fail_addr = port_q.addr;
    assign rdata     = bus_rdata;
    assign bus_stb   = port_q.busy;
    assign bus_we    = port_q.we;
    assign bus_addr  = port_q.addr;
    assign bus_wdata = port_q.wdata;
    assign bus_size  = port_q.size;

    // R5: a pending beat keeps its request and address until answered
    assert_stb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stb && !bus_ack && !bus_err) |=> (bus_stb && $stable(bus_addr)));
endmodule

// File: rtl/jtag_burst_engine.sv
module jtag_burst_engine
    import jbe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int CRC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_capture,
    input  logic              dbg_shift,
    input  logic              dbg_update,
    input  logic              dbg_tdi,
    output logic              dbg_tdo,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic              bus_stb,
    input  logic              bus_ack,
    input  logic              bus_err
);
    localparam int HDR_W   = 1 + OPC_W + ADDR_W + CNT_W;
    localparam int ERR_W   = ADDR_W + 1;
    localparam int IDX_POS = HDR_W - 2 - OPC_W;
    localparam int DAT_POS = IDX_POS - 1;
    localparam int BCNT_W  = $clog2((CRC_W > DATA_W) ? CRC_W : DATA_W);

    typedef struct packed {
        eng_state_e        st;
        logic [HDR_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  words;
        logic [CNT_W-1:0]  beats;
        logic [1:0]        size;
        logic              rd;
        logic [BCNT_W-1:0] bitcnt;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] wbuf;
        logic [DATA_W-1:0] fetch;
        logic              fetch_vld;
        logic              req;
        logic [CRC_W-1:0]  crc_rx;
        logic              err_flag;
        logic [ADDR_W-1:0] err_addr;
        logic              sel;
        logic [ERR_W-1:0]  outsr;
    } eng_s;

    eng_s eng_d, eng_q;

    logic              crc_clr, crc_en, crc_bit;
    logic [CRC_W-1:0]  crc_val;
    logic              port_start, port_busy, port_done, port_fail;
    logic [ADDR_W-1:0] port_fail_addr;
    logic [DATA_W-1:0] port_rdata;
    logic              reg_clear;

    logic [OPC_W-1:0]  hdr_opc;
    logic [ADDR_W-1:0] hdr_addr;
    logic [CNT_W-1:0]  hdr_cnt;
    logic [BCNT_W-1:0] last_bit;
    logic [5:0]        align_sh;
    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] wr_word;

    assign hdr_opc  = eng_q.cmd[HDR_W-2 -: OPC_W];
    assign hdr_addr = eng_q.cmd[CNT_W +: ADDR_W];
    assign hdr_cnt  = eng_q.cmd[CNT_W-1:0];

    always_comb begin
        case (eng_q.size)
            2'd0:    begin last_bit = BCNT_W'(7);  align_sh = 6'd24; size_mask = DATA_W'(32'h0000_00FF); end
            2'd1:    begin last_bit = BCNT_W'(15); align_sh = 6'd16; size_mask = DATA_W'(32'h0000_FFFF); end
            default: begin last_bit = BCNT_W'(31); align_sh = 6'd0;  size_mask = '1; end
        endcase
    end

    assign wr_word = {dbg_tdi, eng_q.word[DATA_W-1:1]} >> align_sh;

    always_comb begin
        eng_d      = eng_q;
        crc_clr    = 1'b0;
        crc_en     = 1'b0;
        crc_bit    = 1'b0;
        port_start = 1'b0;
        reg_clear  = 1'b0;

        // issue a queued beat once the port is free
        if (eng_q.req && !port_busy) begin
            port_start  = 1'b1;
            eng_d.req   = 1'b0;
            eng_d.addr  = eng_q.addr + (ADDR_W'(1) << eng_q.size);
            eng_d.beats = eng_q.beats - 1'b1;
        end
        if (port_done && eng_q.rd) begin
            eng_d.fetch     = port_rdata & size_mask;
            eng_d.fetch_vld = 1'b1;
        end
        if (port_fail && !eng_q.err_flag) begin
            eng_d.err_flag = 1'b1;
            eng_d.err_addr = port_fail_addr;
        end

        if (dbg_update && eng_q.st != ST_IDLE) begin
            eng_d.st = ST_IDLE;
            if (eng_q.rd) begin
                eng_d.req   = 1'b0;
                eng_d.beats = '0;
            end
        end else begin
            case (eng_q.st)
                ST_IDLE: begin
                    if (dbg_capture) begin
                        eng_d.outsr = eng_q.sel ? '0 : {eng_q.err_addr, eng_q.err_flag};
                    end else if (dbg_shift) begin
                        eng_d.cmd   = {dbg_tdi, eng_q.cmd[HDR_W-1:1]};
                        eng_d.outsr = eng_q.outsr >> 1;
                    end else if (dbg_update && !eng_q.cmd[HDR_W-1]) begin
                        case (hdr_opc)
                            OPC_WR8, OPC_WR16, OPC_WR32,
                            OPC_RD8, OPC_RD16, OPC_RD32: begin
                                if (hdr_cnt != '0) begin
                                    eng_d.addr      = hdr_addr;
                                    eng_d.words     = hdr_cnt;
                                    eng_d.beats     = hdr_cnt;
                                    eng_d.size      = hdr_opc[1:0] - 2'd1;
                                    eng_d.rd        = hdr_opc[2];
                                    eng_d.bitcnt    = '0;
                                    eng_d.fetch_vld = 1'b0;
                                    eng_d.req       = hdr_opc[2];
                                    eng_d.st        = hdr_opc[2] ? ST_RD_WAIT : ST_WR_START;
                                    crc_clr         = 1'b1;
                                end
                            end
                            OPC_REG_WR: begin
                                if (!eng_q.cmd[IDX_POS] && eng_q.cmd[DAT_POS]) reg_clear = 1'b1;
                            end
                            OPC_REG_SEL: eng_d.sel = eng_q.cmd[IDX_POS];
                            default: ;
                        endcase
                    end
                end
                ST_WR_START: begin
                    if (dbg_shift && dbg_tdi) begin
                        eng_d.st     = ST_WR_DATA;
                        eng_d.bitcnt = '0;
                    end
                end
                ST_WR_DATA: begin
                    if (dbg_shift) begin
                        crc_en       = 1'b1;
                        crc_bit      = dbg_tdi;
                        eng_d.word   = {dbg_tdi, eng_q.word[DATA_W-1:1]};
                        eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                        if (eng_q.bitcnt == last_bit) begin
                            eng_d.wbuf   = wr_word;
                            eng_d.req    = 1'b1;
                            eng_d.bitcnt = '0;
                            eng_d.words  = eng_q.words - 1'b1;
                            if (eng_q.words == CNT_W'(1)) eng_d.st = ST_WR_CRC;
                        end
                    end
                end
                ST_WR_CRC: begin
                    if (dbg_shift) begin
                        eng_d.crc_rx = {dbg_tdi, eng_q.crc_rx[CRC_W-1:1]};
                        eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                        if (eng_q.bitcnt == BCNT_W'(CRC_W-1)) eng_d.st = ST_WR_MATCH;
                    end
                end
                ST_WR_MATCH: begin
                    if (dbg_shift) eng_d.st = ST_DONE;
                end
                ST_RD_WAIT: begin
                    if (dbg_shift && eng_q.fetch_vld) begin
                        eng_d.st        = ST_RD_DATA;
                        eng_d.word      = eng_q.fetch;
                        eng_d.fetch_vld = 1'b0;
                        eng_d.bitcnt    = '0;
                        if (eng_q.beats != '0) eng_d.req = 1'b1;
                    end
                end
                ST_RD_DATA: begin
                    if (dbg_shift) begin
                        crc_en       = 1'b1;
                        crc_bit      = eng_q.word[0];
                        eng_d.word   = eng_q.word >> 1;
                        eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                        if (eng_q.bitcnt == last_bit) begin
                            eng_d.bitcnt = '0;
                            eng_d.words  = eng_q.words - 1'b1;
                            if (eng_q.words == CNT_W'(1)) begin
                                eng_d.st = ST_RD_CRC;
                            end else begin
                                eng_d.word      = eng_q.fetch;
                                eng_d.fetch_vld = 1'b0;
                                if (eng_q.beats != '0) eng_d.req = 1'b1;
                            end
                        end
                    end
                end
                ST_RD_CRC: begin
                    if (dbg_shift) begin
                        eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                        if (eng_q.bitcnt == BCNT_W'(CRC_W-1)) eng_d.st = ST_DONE;
                    end
                end
                default: ;
            endcase
        end

        if (reg_clear) begin
            eng_d.err_flag = 1'b0;
            eng_d.err_addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    always_comb begin
        case (eng_q.st)
            ST_IDLE:     dbg_tdo = eng_q.outsr[0];
            ST_RD_WAIT:  dbg_tdo = eng_q.fetch_vld;
            ST_RD_DATA:  dbg_tdo = eng_q.word[0];
            ST_RD_CRC:   dbg_tdo = crc_val[eng_q.bitcnt];
            ST_WR_MATCH: dbg_tdo = (eng_q.crc_rx == crc_val);
            default:     dbg_tdo = 1'b0;
        endcase
    end

    jbe_crc32 #(.CRC_W(CRC_W)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (crc_clr),
        .en     (crc_en),
        .bit_in (crc_bit),
        .crc    (crc_val)
    );

    jbe_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (port_start),
        .we        (!eng_q.rd),
        .addr      (eng_q.addr),
        .wdata     (eng_q.wbuf),
        .size      (eng_q.size),
        .busy      (port_busy),
        .done      (port_done),
        .fail      (port_fail),
        .fail_addr (port_fail_addr),
        .rdata     (port_rdata),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_we    (bus_we),
        .bus_size  (bus_size),
        .bus_stb   (bus_stb),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err)
    );

    // R4: the ready marker is followed by payload bits
    assert_ready_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_RD_WAIT && dbg_shift && !dbg_update && dbg_tdo) |=> (eng_q.st == ST_RD_DATA));

    // R7: a payload phase always has at least one word left
    assert_count_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WR_DATA || eng_q.st == ST_RD_DATA) |-> (eng_q.words != '0));

    // R3: the computed code stays put while the host's code arrives and is compared
    assert_crc_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_WR_CRC || eng_q.st == ST_WR_MATCH) |=> $stable(crc_val));

    // R8: the error flag only drops through an explicit clear
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.err_flag && !reg_clear) |=> eng_q.err_flag);
endmodule

// File: tb/jtag_burst_engine_test.sv
module jtag_burst_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_capture = 1'b0, dbg_shift = 1'b0, dbg_update = 1'b0, dbg_tdi = 1'b0;
    logic        dbg_tdo;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_we, bus_stb;
    logic [1:0]  bus_size;
    logic        bus_ack = 1'b0, bus_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_burst_engine uut (
        .clk(clk), .rst_n(rst_n),
        .dbg_capture(dbg_capture), .dbg_shift(dbg_shift), .dbg_update(dbg_update),
        .dbg_tdi(dbg_tdi), .dbg_tdo(dbg_tdo),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_we(bus_we), .bus_size(bus_size), .bus_stb(bus_stb),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    // bus slave model
    logic [7:0]  mem [0:255];
    logic        err_en = 1'b0;
    logic [31:0] err_at = '0;
    int          beats_seen = 0;

    always @(negedge clk) begin
        if (bus_stb && !bus_ack && !bus_err) begin
            beats_seen++;
            if (err_en && bus_addr == err_at) begin
                bus_err <= 1'b1;
            end else begin
                logic [31:0] rd;
                rd = '0;
                for (int i = 0; i < (1 << bus_size); i++) begin
                    if (bus_we) mem[(bus_addr + i) & 255] = bus_wdata[8*i +: 8];
                    else        rd[8*i +: 8] = mem[(bus_addr + i) & 255];
                end
                bus_rdata <= rd;
                bus_ack   <= 1'b1;
            end
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end
    end

    // scoreboard
    typedef struct {
        int          rq;
        logic [63:0] v;
    } item_t;
    item_t exp_q[$];
    item_t act_q[$];
    int    checks = 0, fails = 0;
    bit    finished = 0;

    task automatic expect_item(input int rq, input logic [63:0] v);
        item_t it;
        it.rq = rq; it.v = v;
        exp_q.push_back(it);
    endtask

    task automatic observe(input int rq, input logic [63:0] v);
        item_t it;
        it.rq = rq; it.v = v;
        act_q.push_back(it);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                item_t e;
                item_t a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a.v !== e.v) begin
                    fails++;
                    $display("FAIL R%0d actual=%0h expected=%0h", e.rq, a.v, e.v);
                end
            end
        end
    end

    function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b);
        return (c >> 1) ^ (((c[0] ^ b) != 1'b0) ? 32'hEDB88320 : 32'h0);
    endfunction

    task automatic sbit(input logic b, output logic t);
        @(negedge clk);
        dbg_shift = 1'b1;
        dbg_tdi   = b;
        #1 t = dbg_tdo;
        @(posedge clk);
        #1 dbg_shift = 1'b0;
    endtask

    task automatic do_capture();
        @(negedge clk); dbg_capture = 1'b1;
        @(posedge clk); #1 dbg_capture = 1'b0;
    endtask

    task automatic do_update();
        @(negedge clk); dbg_update = 1'b1;
        @(posedge clk); #1 dbg_update = 1'b0;
    endtask

    task automatic send_header(input logic flag, input logic [3:0] op,
                               input logic [31:0] addr, input logic [15:0] cnt);
        logic [52:0] h;
        logic t;
        h = {flag, op, addr, cnt};
        do_capture();
        for (int i = 0; i < 53; i++) sbit(h[i], t);
        do_update();
    endtask

    // register scan: nd data bits (captured), then nc command bits
    task automatic reg_scan(input int nd, input logic [63:0] data,
                            input int nc, input logic [5:0] cmd, output logic [63:0] cap);
        logic t;
        cap = '0;
        do_capture();
        for (int i = 0; i < nd; i++) begin sbit(data[i], t); cap[i] = t; end
        for (int i = 0; i < nc; i++) sbit(cmd[i], t);
        do_update();
    endtask

    task automatic read_err(output logic [63:0] cap);
        reg_scan(33, 64'h0, 5, 6'b000000, cap);
    endtask

    logic [31:0] wd [0:7];

    task automatic wr_burst(input logic [3:0] op, input logic [31:0] addr, input int cnt,
                            input logic bad, output logic match);
        int nb;
        logic [31:0] c;
        logic t;
        nb = 8 << (op[1:0] - 2'd1);
        send_header(1'b0, op, addr, 16'(cnt));
        do_capture();
        sbit(1'b0, t); sbit(1'b0, t);
        sbit(1'b1, t);
        c = 32'hFFFFFFFF;
        for (int w = 0; w < cnt; w++)
            for (int b = 0; b < nb; b++) begin
                c = crc_bit(c, wd[w][b]);
                sbit(wd[w][b], t);
            end
        if (bad) c = c ^ 32'h1;
        for (int b = 0; b < 32; b++) sbit(c[b], t);
        sbit(1'b0, match);
        do_update();
        repeat (6) @(negedge clk);
    endtask

    logic [31:0] rw [0:7];

    task automatic rd_burst(input logic [3:0] op, input logic [31:0] addr, input int cnt,
                            output logic [31:0] rcrc, output int waits);
        int nb;
        logic t;
        nb = 8 << (op[1:0] - 2'd1);
        send_header(1'b0, op, addr, 16'(cnt));
        do_capture();
        waits = 0;
        t = 1'b0;
        while (!t && waits < 50) begin
            sbit(1'b0, t);
            if (!t) waits++;
        end
        for (int w = 0; w < cnt; w++) begin
            rw[w] = '0;
            for (int b = 0; b < nb; b++) begin sbit(1'b0, t); rw[w][b] = t; end
        end
        for (int b = 0; b < 32; b++) begin sbit(1'b0, t); rcrc[b] = t; end
        do_update();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] mem_word(input logic [31:0] a, input int nbytes);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < nbytes; i++) v[8*i +: 8] = mem[(a + i) & 255];
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] cap;
        logic        m;
        logic [31:0] rc, ec;
        int          waits, b0;

        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        expect_item(1, 0); observe(1, {63'h0, dbg_tdo});
        expect_item(1, 0); observe(1, {63'h0, bus_stb});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        read_err(cap);
        expect_item(1, 0); observe(1, cap); // R1 error register clear

        // R2 R3 R6 R5: two 32-bit words written, correct check code
        wd[0] = 32'h11223344; wd[1] = 32'hA5A55A5A;
        b0 = beats_seen;
        wr_burst(4'd3, 32'h20, 2, 1'b0, m);
        expect_item(3, 1); observe(3, {63'h0, m});                           // R3 match 1, R6 code
        expect_item(5, 64'hA5A55A5A11223344);
        observe(5, {mem_word(32'h24, 4), mem_word(32'h20, 4)});              // R5 little-endian, step 4
        expect_item(7, 2); observe(7, 64'(beats_seen - b0));                 // R7 exact beat count

        // R3: corrupted check code gives match 0
        wd[0] = 32'hDEADBEEF;
        wr_burst(4'd3, 32'h40, 1, 1'b1, m);
        expect_item(3, 0); observe(3, {63'h0, m});

        // R4 R6: read two 32-bit words back
        rd_burst(4'd7, 32'h20, 2, rc, waits);
        expect_item(4, 1); observe(4, 64'(waits >= 1));                      // R4 zeros before marker
        expect_item(4, {mem_word(32'h24, 4), mem_word(32'h20, 4)});
        observe(4, {rw[1], rw[0]});
        ec = 32'hFFFFFFFF;
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 32; b++) ec = crc_bit(ec, mem_word(32'h20 + 4*w, 4) >> b);
        expect_item(6, ec); observe(6, rc);                                  // R6 read code

        // R5: byte reads step by one byte
        b0 = beats_seen;
        rd_burst(4'd5, 32'h21, 3, rc, waits);
        expect_item(5, 64'h0000_0022_0000_0033); observe(5, {rw[1], rw[0]});
        expect_item(5, 64'h11); observe(5, 64'(rw[2]));
        expect_item(7, 3); observe(7, 64'(beats_seen - b0));                 // R7

        // R5: half-word writes
        wd[0] = 32'h0000BEEF; wd[1] = 32'h00001234;
        wr_burst(4'd2, 32'h50, 2, 1'b0, m);
        expect_item(5, 64'h1234BEEF); observe(5, 64'(mem_word(32'h50, 4)));
        expect_item(3, 1); observe(3, {63'h0, m});

        // R8 R9: bus error on the second beat of a write burst
        err_en = 1'b1; err_at = 32'h64;
        wd[0] = 32'h01020304; wd[1] = 32'h05060708;
        b0 = beats_seen;
        wr_burst(4'd3, 32'h60, 2, 1'b0, m);
        err_en = 1'b0;
        expect_item(9, 1); observe(9, {63'h0, m});                           // R9 framing intact
        expect_item(9, 2); observe(9, 64'(beats_seen - b0));                 // R9 all beats run
        read_err(cap);
        expect_item(8, {31'h0, 32'h64, 1'b1}); observe(8, cap);              // R8 flag and address

        // R10: index 1 captures zeros, index 0 again shows the register
        reg_scan(0, 64'h0, 6, {1'b0, 4'hD, 1'b1}, cap);
        read_err(cap);
        expect_item(10, 0); observe(10, cap);
        reg_scan(0, 64'h0, 6, {1'b0, 4'hD, 1'b0}, cap);
        read_err(cap);
        expect_item(10, {31'h0, 32'h64, 1'b1}); observe(10, cap);

        // R8: clear with a one-bit write of 1
        reg_scan(1, 64'h1, 6, {1'b0, 4'h9, 1'b0}, cap);
        read_err(cap);
        expect_item(8, 0); observe(8, cap);

        // R2 R7 R10: headers that start nothing
        b0 = beats_seen;
        send_header(1'b1, 4'd3, 32'h80, 16'd1);  // R2 flag set
        send_header(1'b0, 4'd0, 32'h80, 16'd1);  // R10 no-op
        send_header(1'b0, 4'd4, 32'h80, 16'd1);  // R10 unused opcode
        send_header(1'b0, 4'd7, 32'h80, 16'd0);  // R7 zero count
        repeat (10) @(negedge clk);
        expect_item(2, 0); observe(2, 64'(beats_seen - b0));
        read_err(cap);
        expect_item(10, 0); observe(10, cap);    // still idle and clean

        repeat (5) @(negedge clk);
        while (act_q.size() > 0) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule